// File: doc/BRIEF.md
# Ethernet PHY Management Access Register

This block turns one 32-bit software-visible word into clause-22 management transactions towards an external Ethernet PHY. Software writes the word with a direction flag, an 8-bit register address and 16 data bits. The block then clocks a complete serial frame out on the management clock and data pins. Software keeps reading the same word until the flag shows that the transaction has finished.

The flag has a different meaning for each direction. A write is started with the flag set, and the flag stays high until the frame has been sent. A read is started with the flag clear, and the flag rises only after the 16 data bits returned by the PHY have been captured into the data field. The management clock comes from the system clock through a clock enable, and it only toggles while a transaction runs. Writes to the word that arrive while a transaction is in progress are dropped.

Top module: `mdio_access_reg`

## Requirements
- R1: After reset the word reads 0, `mdc` is low and `mdio_oe` is low.
- R2: A write to the word with bit 31 = 1 sends the frame MSB first. The frame is PREAMBLE_BITS ones, start 01, opcode 01, PHY_ADDR (5 bits), register address bits [20:16] of the written word, turnaround 10, then data bits [15:0]. Each bit is driven for one full MDC period.
- R3: While such a write runs, bit 31 reads 1. When the write is done, bit 31 reads 0 and bits [23:16] and [15:0] read back the written values.
- R4: A write with bit 31 = 0 starts a read frame with opcode 10. The block drives only the first PREAMBLE_BITS+14 bits and holds `mdio_oe` low for the 18 bit times that follow (turnaround and data).
- R5: During a read, bit 31 reads 0. When the read is done, bit 31 reads 1 and bits [15:0] hold the 16 bits sampled from `mdio_i` in bit times PREAMBLE_BITS+16 to PREAMBLE_BITS+31, MSB first.
- R6: Only bits [20:16] of the address field reach the frame. All 8 address bits [23:16] read back as written, and bits [30:24] always read 0.
- R7: While a transaction runs, each high phase and each low phase of `mdc` lasts exactly MDC_HALF_CYCLES clock cycles. When no transaction runs, `mdc` stays low.
- R8: A write to the word while a transaction is in progress changes neither the word nor the frame being sent.
- R9: Every transaction ends exactly (PREAMBLE_BITS+32)·2·MDC_HALF_CYCLES cycles after the accepting edge.
- R10: `mdio_o` and `mdio_oe` change only when `mdc` falls or when a transaction starts. They are never updated on a rising `mdc` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | One-cycle write strobe for the access word |
| reg_wdata | input | 32 | Written value: flag [31], register address [23:16], data [15:0] |
| reg_rdata | output | 32 | Current access word |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data driven towards the PHY |
| mdio_oe | output | 1 | Output enable for the bidirectional data pad |
| mdio_i | input | 1 | Serial data received from the pad |

## Verification
The assertions assume that `reg_wr` is a single-cycle strobe and that `mdio_i` is stable around each rising `mdc` edge of the read data phase. They also rely on reset being asserted before the first strobe. The bench applies every write strobe for exactly one cycle between falling clock edges. Its PHY model changes `mdio_i` only in the cycle in which `mdc` falls, and only after the block has released the line, so the sampled value is always settled. A second strobe is injected in the middle of both a write and a read, which exercises the dropped-write path under both flag meanings.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   // opcode field of a clause-22 frame
   typedef enum logic [1:0] {
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10
   } mdio_op_e;

   localparam logic [1:0] SOF_BITS    = 2'b01;
   localparam logic [1:0] TA_DRIVEN   = 2'b10;
   localparam logic [1:0] TA_RELEASED = 2'b00;
   // bits after the preamble: start, op, phy, reg, turnaround, data
   localparam int FRAME_TAIL_BITS = 32;
   // bits after the preamble still driven by the master on a read
   localparam int READ_DRIVEN_TAIL = 14;
   localparam int DATA_BITS = 16;

   typedef struct packed {
      logic        flag;
      logic [6:0]  spare;
      logic [7:0]  regad;
      logic [15:0] data;
   } access_word_t;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
   parameter int MDC_HALF_CYCLES = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise,
   output logic fall
);
   logic tick;
   logic mdc_q;

   generate
      if (MDC_HALF_CYCLES == 1) begin : g_toggle
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(MDC_HALF_CYCLES);
         localparam logic [CW-1:0] LAST = CW'(MDC_HALF_CYCLES - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    cnt <= '0;
            else if (!run || cnt == LAST)  cnt <= '0;
            else                           cnt <= cnt + 1'b1;
         end
         assign tick = run && (cnt == LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mdc_q <= 1'b0;
      else if (!run) mdc_q <= 1'b0;
      else if (tick) mdc_q <= ~mdc_q;
   end

   assign mdc  = mdc_q;
   assign rise = tick && !mdc_q;
   assign fall = tick && mdc_q;

   // R7: the clock only runs while a transaction is active
   assert_stop_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !mdc_q);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq import mdio_pkg::*; #(
   parameter int         PREAMBLE_BITS   = 32,
   parameter int         MDC_HALF_CYCLES = 25,
   parameter logic [4:0] PHY_ADDR        = 5'd1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        start_wr,
   input  logic [4:0]  start_regad,
   input  logic [15:0] start_data,
   input  logic        rise,
   input  logic        fall,
   input  logic        mdio_i,
   output logic        busy,
   output logic        done,
   output logic [15:0] rd_data,
   output logic        mdio_o,
   output logic        mdio_oe
);
   localparam int FRAME_BITS = PREAMBLE_BITS + FRAME_TAIL_BITS;
   localparam int IW         = $clog2(FRAME_BITS);
   localparam logic [IW-1:0] IDX_LAST    = IW'(FRAME_BITS - 1);
   localparam logic [IW-1:0] IDX_RELEASE = IW'(PREAMBLE_BITS + READ_DRIVEN_TAIL);
   localparam logic [IW-1:0] IDX_RDATA   = IW'(PREAMBLE_BITS + READ_DRIVEN_TAIL + 2);
   localparam int TXN_CYCLES = FRAME_BITS * 2 * MDC_HALF_CYCLES;
   localparam int BW         = $clog2(TXN_CYCLES + 2);

   logic [FRAME_BITS-1:0] sh_q, oe_q, frame_d, mask_d;
   logic [IW-1:0]         idx_q;
   logic                  busy_q, wr_q;
   logic [15:0]           rd_q;

   always_comb begin
      frame_d = {{PREAMBLE_BITS{1'b1}}, SOF_BITS,
                 start_wr ? OP_WRITE : OP_READ, PHY_ADDR, start_regad,
                 start_wr ? TA_DRIVEN : TA_RELEASED,
                 start_wr ? start_data : 16'h0000};
      mask_d  = start_wr ? {FRAME_BITS{1'b1}}
                         : {{(PREAMBLE_BITS + READ_DRIVEN_TAIL){1'b1}},
                            {(2 + DATA_BITS){1'b0}}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         wr_q   <= 1'b0;
         idx_q  <= '0;
         sh_q   <= '0;
         oe_q   <= '0;
         rd_q   <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         wr_q   <= start_wr;
         idx_q  <= '0;
         sh_q   <= frame_d;
         oe_q   <= mask_d;
      end else if (busy_q) begin
         if (rise && !wr_q && idx_q >= IDX_RDATA)
            rd_q <= {rd_q[14:0], mdio_i};
         if (fall) begin
            if (idx_q == IDX_LAST) begin
               busy_q <= 1'b0;
            end else begin
               idx_q <= idx_q + 1'b1;
               sh_q  <= sh_q << 1;
               oe_q  <= oe_q << 1;
            end
         end
      end
   end

   assign busy    = busy_q;
   assign done    = busy_q && fall && (idx_q == IDX_LAST);
   assign rd_data = rd_q;
   assign mdio_o  = busy_q & sh_q[FRAME_BITS-1];
   assign mdio_oe = busy_q & oe_q[FRAME_BITS-1];

   // R9 checker: count the cycles of the running transaction
   logic [BW-1:0] span_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       span_q <= '0;
      else if (!busy_q) span_q <= '0;
      else              span_q <= span_q + 1'b1;
   end

   assert_bounded_txn_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> span_q < BW'(TXN_CYCLES));

   assert_read_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !wr_q && idx_q >= IDX_RELEASE) |-> !mdio_oe);
endmodule

// File: rtl/mdio_access_reg.sv
module mdio_access_reg import mdio_pkg::*; #(
   parameter int         MDC_HALF_CYCLES = 25,
   parameter int         PREAMBLE_BITS   = 32,
   parameter logic [4:0] PHY_ADDR        = 5'd1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   generate
      if (MDC_HALF_CYCLES < 1) begin : g_bad_div
         $error("MDC_HALF_CYCLES must be at least 1");
      end
      if (PREAMBLE_BITS < 1 || PREAMBLE_BITS > 32) begin : g_bad_pre
         $error("PREAMBLE_BITS must lie in 1..32");
      end
   endgenerate

   access_word_t wword;
   assign wword = access_word_t'(reg_wdata);
   logic unused_spare;
   assign unused_spare = ^wword.spare;

   logic        busy, done, rise, fall, start;
   logic [15:0] rd_data;
   logic        flag_q, op_wr_q;
   logic [7:0]  addr_q;
   logic [15:0] data_q;

   assign start = reg_wr && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         op_wr_q <= 1'b0;
         addr_q  <= '0;
         data_q  <= '0;
      end else if (start) begin
         flag_q  <= wword.flag;
         op_wr_q <= wword.flag;
         addr_q  <= wword.regad;
         data_q  <= wword.data;
      end else if (done) begin
         flag_q <= !op_wr_q;
         if (!op_wr_q) data_q <= rd_data;
      end
   end

   assign reg_rdata = {flag_q, 7'b0, addr_q, data_q};

   mdio_clk_gen #(
      .MDC_HALF_CYCLES(MDC_HALF_CYCLES)
   ) u_clk (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy),
      .mdc  (mdc),
      .rise (rise),
      .fall (fall)
   );

   mdio_frame_seq #(
      .PREAMBLE_BITS  (PREAMBLE_BITS),
      .MDC_HALF_CYCLES(MDC_HALF_CYCLES),
      .PHY_ADDR       (PHY_ADDR)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_wr   (wword.flag),
      .start_regad(wword.regad[4:0]),
      .start_data (wword.data),
      .rise       (rise),
      .fall       (fall),
      .mdio_i     (mdio_i),
      .busy       (busy),
      .done       (done),
      .rd_data    (rd_data),
      .mdio_o     (mdio_o),
      .mdio_oe    (mdio_oe)
   );

   assert_idle_mdc_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);

   assert_write_flag_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_wr_q) |-> reg_rdata[31]);

   assert_read_flag_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !op_wr_q) |-> !reg_rdata[31]);

   assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr) |=> $stable(addr_q));

   assert_spare_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[30:24] == 7'b0);

   assert_stable_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

// File: tb/test_mdio_access_reg.sv
module test_mdio_access_reg;
   localparam int         HALF  = 3;
   localparam logic [4:0] PHY   = 5'h1B;
   localparam int         TXN   = 64 * 2 * HALF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b0;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   mdio_access_reg #(
      .MDC_HALF_CYCLES(HALF),
      .PREAMBLE_BITS  (32),
      .PHY_ADDR       (PHY)
   ) i_mdio_access_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .mdc      (mdc),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .mdio_i   (mdio_i)
   );

   typedef struct {
      logic [63:0] frame;
      int          nbits;
      string       tag;
   } exp_t;
   exp_t sb_q[$];

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // PHY model and frame monitor, all sampled on the falling clock edge
   logic [63:0] cap = '0;
   int          ncap = 0;
   bit          cur_read = 0;
   logic [15:0] resp_val = '0;
   bit          resp_on = 0;
   int          resp_idx = 0;
   logic        p_mdc = 0, p_o = 0, p_oe = 0;
   int          hi_len = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (mdc && !p_mdc) begin
            chk(mdio_o == p_o && mdio_oe == p_oe, "R10 line moved on rising mdc",
                {62'b0, mdio_oe, mdio_o}, {62'b0, p_oe, p_o});
            if (mdio_oe) begin
               cap = {cap[62:0], mdio_o};
               ncap++;
               if (sb_q.size() > 0 && ncap == sb_q[0].nbits) begin
                  exp_t e;
                  logic [63:0] m;
                  e = sb_q.pop_front();
                  m = (e.nbits == 64) ? '1 : ((64'd1 << e.nbits) - 1);
                  chk((cap & m) == (e.frame >> (64 - e.nbits)), e.tag,
                      cap & m, e.frame >> (64 - e.nbits));
                  if (cur_read) begin
                     resp_on  = 1;
                     resp_idx = 0;
                  end
               end
            end
         end
         if (!mdc && p_mdc) begin
            chk(hi_len == HALF, "R7 mdc high phase length", 64'(hi_len), 64'(HALF));
            if (resp_on) begin
               if (resp_idx < 18) begin
                  mdio_i = (resp_idx < 2) ? 1'b0 : resp_val[17 - resp_idx];
                  resp_idx++;
               end else begin
                  mdio_i  = 1'b0;
                  resp_on = 0;
               end
            end
         end
         hi_len = mdc ? (p_mdc ? hi_len + 1 : 1) : 0;
      end
      p_mdc = mdc;
      p_o   = mdio_o;
      p_oe  = mdio_oe;
   end

   function automatic logic [63:0] mk_frame(bit wr, logic [4:0] ra, logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, PHY, ra,
              wr ? 2'b10 : 2'b00, wr ? d : 16'h0000};
   endfunction

   // driver: pushes the expected frame, then runs and polls one transaction
   task automatic txn(input bit wr, input logic [7:0] a, input logic [15:0] d,
                      input logic [6:0] spare, input logic [15:0] phy_resp,
                      input bit poke);
      exp_t e;
      int t;
      logic [31:0] snap, want;
      e.frame = mk_frame(wr, a[4:0], d);
      e.nbits = wr ? 64 : 46;
      e.tag   = wr ? "R2 write frame (R6 low address bits)" : "R4 read frame driven part";
      sb_q.push_back(e);
      @(negedge clk);
      ncap      = 0;
      cur_read  = !wr;
      resp_val  = phy_resp;
      reg_wr    = 1'b1;
      reg_wdata = {wr, spare, a, d};
      @(negedge clk);
      reg_wr = 1'b0;
      t = 1;
      chk(reg_rdata[31] == wr, wr ? "R3 flag high while writing" : "R5 flag low while reading",
          64'(reg_rdata[31]), 64'(wr));
      if (poke) begin
         repeat (40) @(negedge clk);
         t += 40;
         snap      = reg_rdata;
         reg_wr    = 1'b1;
         reg_wdata = {!wr, 7'h7F, ~a, ~d};
         @(negedge clk);
         reg_wr = 1'b0;
         t++;
         chk(reg_rdata == snap, "R8 write during busy ignored", 64'(reg_rdata), 64'(snap));
      end
      while (reg_rdata[31] == wr && t < 5000) begin
         @(negedge clk);
         t++;
      end
      chk(t <= TXN + 3, "R9 completion bound", 64'(t), 64'(TXN + 3));
      want = wr ? {1'b0, 7'b0, a, d} : {1'b1, 7'b0, a, phy_resp};
      chk(reg_rdata == want, wr ? "R3/R6 word after write" : "R5/R6 word after read",
          64'(reg_rdata), 64'(want));
      chk(ncap == e.nbits, wr ? "R2 driven bit count" : "R4 driven bit count before release",
          64'(ncap), 64'(e.nbits));
      chk(sb_q.size() == 0, "R2/R4 scoreboard drained", 64'(sb_q.size()), 64'd0);
      repeat (30) begin
         @(negedge clk);
         chk(!mdc, "R7 mdc idle low", 64'(mdc), 64'd0);
      end
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(reg_rdata == 32'h0, "R1 word after reset", 64'(reg_rdata), 64'h0);
      chk(!mdc, "R1 mdc after reset", 64'(mdc), 64'h0);
      chk(!mdio_oe, "R1 oe after reset", 64'(mdio_oe), 64'h0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      txn(1'b1, 8'h03, 16'hA5C3, 7'h00, 16'h0000, 1'b1);
      txn(1'b1, 8'hE9, 16'h0001, 7'h55, 16'h0000, 1'b0);
      txn(1'b0, 8'h02, 16'h1234, 7'h00, 16'h796D, 1'b0);
      txn(1'b0, 8'hFF, 16'h0000, 7'h2A, 16'h8001, 1'b1);
      txn(1'b1, 8'h00, 16'hFFFF, 7'h00, 16'h0000, 1'b0);
      txn(1'b0, 8'h1F, 16'hFFFF, 7'h00, 16'h0000, 1'b0);
      summary();
      $finish;
   end
endmodule